// File: doc/BRIEF.md
# S/T Multiframe Overhead Bit Controller

This block generates the per-frame overhead bits that a basic-rate S/T line-termination transceiver sends over a 20-frame multiframe. It also pulls the Q-channel out of the received Fa bits. A frame counter steps once per frame strobe. From the counter value the block derives the transmit Fa bit and its complement N, the multiframe marker M, and the S bit. The S bit carries one bit of one of two 4-bit S-subchannel words. These words are captured at the start of each multiframe.

Until the controlling logic confirms multiframe alignment with the sync command, the transmit Fa bit echoes the most recently received Fa bit. While the command is held high, the block drives its own Fa pattern. In the receive direction, the Fa bits of the four Q frames are collected into a nibble. That nibble is presented with a one-cycle valid pulse once the last Q bit has arrived. Line coding, frame alignment detection and the bit clock belong to other blocks.

Top module: `stmf_ctrl`

## Requirements
- R1: The frame number runs 1..20 and is shown on frame_idx_o. It resets to 20, so the first strobe enters frame 1. Each frame_i pulse advances it by one, and 20 wraps to 1. The new value appears in the cycle after the strobe edge.
- R2: A resync_i pulse forces the frame number to 1 whatever its current value, and it takes priority over frame_i. All frame-1 entry actions happen at the same time: S words are captured, the mode is sampled and Q1 is taken.
- R3: In generate mode tx_fa_o is 1 in frames 1, 6, 11 and 16 and 0 in every other frame.
- R4: tx_n_o is always the inverse of tx_fa_o.
- R5: tx_m_o is 1 in frame 1 only, in both modes.
- R6: tx_s_o carries the subchannel-1 word bits 0,1,2,3 in frames 1, 6, 11 and 16, and the subchannel-2 word bits 0,1,2,3 in frames 2, 7, 12 and 17. In all other frames it is 1.
- R7: s1_word_i and s2_word_i are sampled only on entry to frame 1. Changes at any other time have no effect until the next frame 1.
- R8: rx_fa_i is sampled with the strobe that enters frames 1, 6, 11 and 16 and stored into q_nibble_o bits 0, 1, 2 and 3 (Q1..Q4). In the cycle after the strobe that enters frame 16, q_nibble_o shows all four bits and q_valid_o is high for exactly one cycle.
- R9: msync_i is sampled at every strobe. If it was low, tx_fa_o for that frame equals rx_fa_i sampled at that strobe (mirror mode). If it was high, the frame uses generate mode.
- R10: After reset: frame_idx_o=20, tx_fa_o=0, tx_n_o=1, tx_m_o=0, tx_s_o=1, q_nibble_o=0, q_valid_o=0, stored S words all ones, mirror mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle frame strobe |
| resync_i | input | 1 | Force next frame to frame 1 |
| msync_i | input | 1 | Multiframe sync command (1 = generate Fa) |
| rx_fa_i | input | 1 | Received Fa bit, valid with the strobe |
| s1_word_i | input | 4 | S-subchannel 1 data, bit 0 first |
| s2_word_i | input | 4 | S-subchannel 2 data, bit 0 first |
| tx_fa_o | output | 1 | Transmit Fa bit |
| tx_n_o | output | 1 | Transmit N bit |
| tx_m_o | output | 1 | Transmit M bit |
| tx_s_o | output | 1 | Transmit S bit |
| q_nibble_o | output | 4 | Assembled Q1..Q4, Q1 in bit 0 |
| q_valid_o | output | 1 | One-cycle pulse when q_nibble_o is updated |
| frame_idx_o | output | 5 | Current frame number 1..20 |

## Verification
If the frame counter slips, frame_idx_o shows it one cycle after the offending strobe. The tx_fa_o, tx_m_o and tx_s_o patterns then land in the wrong frames within at most five frames. A wrong mode register or a stale mirror latch shows up on tx_fa_o in the very frame it occurs. An S word captured at the wrong time stays hidden until its bit slot comes round. That can take up to 17 frames, so the stimulus changes the words between strobes throughout each multiframe. A misplaced Q bit shows only on the valid pulse after frame 16.

// File: rtl/stmf_pkg.sv
package stmf_pkg;
  localparam int unsigned MF_LEN = 20;  // frames per multiframe
  localparam int unsigned Q_STEP = 5;   // spacing of Q / S slots
  localparam int unsigned SUB_W  = 4;   // bits per S word and Q nibble
  localparam int unsigned N_SUB  = 2;   // S subchannels

  typedef enum logic {
    FA_MIRROR = 1'b0,
    FA_GEN    = 1'b1
  } fa_mode_e;
endpackage

// File: rtl/stmf_slot_dec.sv
module stmf_slot_dec #(
  parameter int unsigned STEP = stmf_pkg::Q_STEP,
  parameter int unsigned CW   = 5,
  parameter int unsigned IW   = 2
) (
  input  logic [CW-1:0] frame_i,
  output logic [CW-1:0] slot_o,   // position within a 5-frame group, 0-based
  output logic [IW-1:0] grp_o     // group number, 0-based
);
  localparam logic [CW-1:0] STEP_C = CW'(STEP);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic [CW-1:0] zb;
  logic [CW-1:0] grp_full;

  always_comb begin
    zb       = frame_i - ONE_C;
    slot_o   = zb % STEP_C;
    grp_full = zb / STEP_C;
    grp_o    = IW'(grp_full);
  end
endmodule

// File: rtl/stmf_frame_ctr.sv
module stmf_frame_ctr #(
  parameter int unsigned LEN = stmf_pkg::MF_LEN,
  parameter int unsigned CW  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  input  logic          resync_i,
  output logic          evt_o,
  output logic [CW-1:0] nxt_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST_C  = CW'(LEN);
  localparam logic [CW-1:0] FIRST_C = CW'(1);

  logic [CW-1:0] cnt_q;

  always_comb begin
    evt_o = frame_i | resync_i;
    if (resync_i)             nxt_o = FIRST_C;
    else if (cnt_q == LAST_C) nxt_o = FIRST_C;
    else                      nxt_o = cnt_q + FIRST_C;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= LAST_C;
    else if (evt_o) cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stmf_tx_gen.sv
module stmf_tx_gen
  import stmf_pkg::*;
#(
  parameter int unsigned NS  = N_SUB,
  parameter int unsigned SW  = SUB_W,
  parameter int unsigned CW  = 5,
  parameter int unsigned IW  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 evt_i,
  input  logic [CW-1:0]        nxt_i,
  input  logic [CW-1:0]        cur_i,
  input  logic [CW-1:0]        cur_slot_i,
  input  logic [IW-1:0]        cur_grp_i,
  input  logic                 msync_i,
  input  logic                 rx_fa_i,
  input  logic [NS-1:0][SW-1:0] s_word_i,
  output logic                 tx_fa_o,
  output logic                 tx_n_o,
  output logic                 tx_m_o,
  output logic                 tx_s_o
);
  localparam logic [CW-1:0] FIRST_C = CW'(1);

  fa_mode_e              mode_q;
  logic                  last_fa_q;
  logic [NS-1:0][SW-1:0] s_q;
  logic [NS-1:0]         s_hit;
  logic [NS-1:0]         s_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= FA_MIRROR;
      last_fa_q <= 1'b0;
      s_q       <= '1;
    end else if (evt_i) begin
      mode_q    <= msync_i ? FA_GEN : FA_MIRROR;
      last_fa_q <= rx_fa_i;
      if (nxt_i == FIRST_C) s_q <= s_word_i;  // snapshot per multiframe
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_sub
    assign s_hit[g] = (cur_slot_i == CW'(g));
    assign s_bit[g] = s_q[g][cur_grp_i];
  end

  always_comb begin
    tx_s_o = 1'b1;
    for (int g = 0; g < NS; g++) begin
      if (s_hit[g]) tx_s_o = s_bit[g];
    end
    tx_fa_o = (mode_q == FA_GEN) ? (cur_slot_i == '0) : last_fa_q;
    tx_n_o  = ~tx_fa_o;
    tx_m_o  = (cur_i == FIRST_C);
  end
endmodule

// File: rtl/stmf_q_rx.sv
module stmf_q_rx #(
  parameter int unsigned SW = stmf_pkg::SUB_W,
  parameter int unsigned CW = 5,
  parameter int unsigned IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  logic [CW-1:0] nxt_slot_i,
  input  logic [IW-1:0] nxt_grp_i,
  input  logic          rx_fa_i,
  output logic [SW-1:0] q_o,
  output logic          q_valid_o
);
  localparam logic [IW-1:0] LAST_G = IW'(SW - 1);

  logic [SW-1:0] acc_q;
  logic [SW-1:0] acc_d;
  logic          cap;
  logic          done;

  always_comb begin
    cap   = evt_i && (nxt_slot_i == '0);
    done  = cap && (nxt_grp_i == LAST_G);
    acc_d = acc_q;
    if (cap) acc_d[nxt_grp_i] = rx_fa_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      q_o       <= '0;
      q_valid_o <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      q_valid_o <= done;
      if (done) q_o <= acc_d;
    end
  end
endmodule

// File: rtl/stmf_ctrl.sv
module stmf_ctrl
  import stmf_pkg::*;
#(
  parameter int unsigned LEN   = MF_LEN,
  parameter int unsigned STEP  = Q_STEP,
  parameter int unsigned SW    = SUB_W,
  parameter int unsigned IDX_W = $clog2(LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             resync_i,
  input  logic             msync_i,
  input  logic             rx_fa_i,
  input  logic [SW-1:0]    s1_word_i,
  input  logic [SW-1:0]    s2_word_i,
  output logic             tx_fa_o,
  output logic             tx_n_o,
  output logic             tx_m_o,
  output logic             tx_s_o,
  output logic [SW-1:0]    q_nibble_o,
  output logic             q_valid_o,
  output logic [IDX_W-1:0] frame_idx_o
);
  localparam int unsigned IW = (SW > 1) ? $clog2(SW) : 1;

  logic                     evt;
  logic [IDX_W-1:0]         nxt, cur;
  logic [IDX_W-1:0]         cur_slot, nxt_slot;
  logic [IW-1:0]            cur_grp, nxt_grp;
  logic [N_SUB-1:0][SW-1:0] s_words;

  assign s_words = {s2_word_i, s1_word_i};

  stmf_frame_ctr #(.LEN(LEN), .CW(IDX_W)) u_ctr (
    .clk_i, .rst_ni, .frame_i, .resync_i,
    .evt_o(evt), .nxt_o(nxt), .cnt_o(cur)
  );

  stmf_slot_dec #(.STEP(STEP), .CW(IDX_W), .IW(IW)) u_dec_cur (
    .frame_i(cur), .slot_o(cur_slot), .grp_o(cur_grp)
  );

  stmf_slot_dec #(.STEP(STEP), .CW(IDX_W), .IW(IW)) u_dec_nxt (
    .frame_i(nxt), .slot_o(nxt_slot), .grp_o(nxt_grp)
  );

  stmf_tx_gen #(.NS(N_SUB), .SW(SW), .CW(IDX_W), .IW(IW)) u_tx (
    .clk_i, .rst_ni, .evt_i(evt), .nxt_i(nxt), .cur_i(cur),
    .cur_slot_i(cur_slot), .cur_grp_i(cur_grp),
    .msync_i, .rx_fa_i, .s_word_i(s_words),
    .tx_fa_o, .tx_n_o, .tx_m_o, .tx_s_o
  );

  stmf_q_rx #(.SW(SW), .CW(IDX_W), .IW(IW)) u_q (
    .clk_i, .rst_ni, .evt_i(evt), .nxt_slot_i(nxt_slot), .nxt_grp_i(nxt_grp),
    .rx_fa_i, .q_o(q_nibble_o), .q_valid_o
  );

  assign frame_idx_o = cur;
endmodule

// File: rtl/stmf_ctrl_chk.sv
module stmf_ctrl_chk #(
  parameter int unsigned LEN   = 20,
  parameter int unsigned IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_i,
  input logic             resync_i,
  input logic             msync_i,
  input logic             rx_fa_i,
  input logic             tx_fa_o,
  input logic             tx_n_o,
  input logic             tx_m_o,
  input logic             q_valid_o,
  input logic [IDX_W-1:0] frame_idx_o
);
  localparam logic [IDX_W-1:0] LAST_C = IDX_W'(LEN);
  localparam logic [IDX_W-1:0] ONE_C  = IDX_W'(1);
  localparam logic [IDX_W-1:0] Q4_C   = IDX_W'(16);

  a_r1_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_idx_o >= ONE_C) && (frame_idx_o <= LAST_C));

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !resync_i && frame_idx_o == LAST_C) |=> (frame_idx_o == ONE_C));

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !resync_i) |=> $stable(frame_idx_o) && $stable(tx_fa_o));

  a_r2_resync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (frame_idx_o == ONE_C));

  a_r4_n_opposite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_n_o != tx_fa_o);

  a_r5_m_frame1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_m_o |-> (frame_idx_o == ONE_C));

  a_r8_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |=> !q_valid_o);

  a_r8_valid_at_q4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |-> (frame_idx_o == Q4_C));

  a_r9_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((frame_i || resync_i) && !msync_i) |=> (tx_fa_o == $past(rx_fa_i)));
endmodule

bind stmf_ctrl stmf_ctrl_chk #(.LEN(LEN), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .frame_i, .resync_i, .msync_i, .rx_fa_i,
  .tx_fa_o, .tx_n_o, .tx_m_o, .q_valid_o, .frame_idx_o
);

// File: tb/stmf_ctrl_tb.sv
module stmf_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0, resync_i = 1'b0, msync_i = 1'b0, rx_fa_i = 1'b0;
  logic [3:0] s1_word_i = 4'h0, s2_word_i = 4'h0;
  logic       tx_fa_o, tx_n_o, tx_m_o, tx_s_o, q_valid_o;
  logic [3:0] q_nibble_o;
  logic [4:0] frame_idx_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  int         m_cnt = 20;
  bit         m_gen = 0, m_last = 0, m_qv = 0;
  logic [3:0] m_s1 = 4'hF, m_s2 = 4'hF, m_acc = 4'h0, m_q = 4'h0;

  always #5 clk_i = ~clk_i;

  stmf_ctrl u_dut (.*);

  function automatic bit e_fa(int c, bit gen, bit last);
    return gen ? ((c - 1) % 5 == 0) : last;
  endfunction

  function automatic bit e_s(int c, logic [3:0] a, logic [3:0] b);
    int sl = (c - 1) % 5;
    int gi = (c - 1) / 5;
    if (sl == 0) return a[gi];
    if (sl == 1) return b[gi];
    return 1'b1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (frame %0d)", req, what, act, exp, m_cnt);
    end
  endtask

  task automatic check_all();
    check("R1", "frame_idx", frame_idx_o, m_cnt);
    check(m_gen ? "R3" : "R9", "tx_fa", tx_fa_o, e_fa(m_cnt, m_gen, m_last));
    check("R4", "tx_n", tx_n_o, !e_fa(m_cnt, m_gen, m_last));
    check("R5", "tx_m", tx_m_o, m_cnt == 1);
    check("R6/R7", "tx_s", tx_s_o, e_s(m_cnt, m_s1, m_s2));
    check("R8", "q_valid", q_valid_o, m_qv);
    check("R8", "q_nibble", q_nibble_o, m_q);
  endtask

  task automatic step(bit rfa, bit ms, bit rs, logic [3:0] a, logic [3:0] b, int gap);
    int nxt;
    @(negedge clk_i);
    frame_i = !rs; resync_i = rs; rx_fa_i = rfa; msync_i = ms;
    s1_word_i = a; s2_word_i = b;
    nxt = rs ? 1 : ((m_cnt == 20) ? 1 : m_cnt + 1);
    if (nxt == 1) begin m_s1 = a; m_s2 = b; end
    m_gen = ms; m_last = rfa; m_cnt = nxt; m_qv = 0;
    if ((nxt - 1) % 5 == 0) begin
      m_acc[(nxt - 1) / 5] = rfa;
      if (nxt == 16) begin m_q = m_acc; m_qv = 1; end
    end
    @(negedge clk_i);
    frame_i = 0; resync_i = 0;
    check_all();
    m_qv = 0;
    for (int i = 0; i < gap; i++) begin
      // R7: words and rx bit toggle between strobes, must not be seen
      s1_word_i = 4'($urandom); s2_word_i = 4'($urandom);
      rx_fa_i = 1'($urandom); msync_i = 1'($urandom);
      @(negedge clk_i);
      check_all();
    end
  endtask

  initial begin
    void'($urandom(32'h5713_0a2c));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10", "frame_idx", frame_idx_o, 20);
    check("R10", "tx_fa", tx_fa_o, 0);
    check("R10", "tx_n", tx_n_o, 1);
    check("R10", "tx_m", tx_m_o, 0);
    check("R10", "tx_s", tx_s_o, 1);
    check("R10", "q_valid", q_valid_o, 0);
    check("R10", "q_nibble", q_nibble_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();

    // R3/R6/R8 directed: one full generated multiframe with known data
    for (int f = 1; f <= 20; f++)
      step(f == 1 || f == 11, 1, 0, 4'b1010, 4'b0110, 1);
    // R8 expected Q = 0101 from rx pattern above
    check("R8", "q_nibble directed", q_nibble_o, 4'b0101);
    // R9 mirror: alternating rx bits with msync low
    for (int f = 0; f < 8; f++) step(f[0], 0, 0, 4'h3, 4'hC, 0);
    // R2 resync mid-multiframe, also together with frame strobe
    step(1, 1, 1, 4'h9, 4'h6, 2);
    for (int f = 0; f < 6; f++) step(0, 1, 0, 4'h0, 4'h0, 0);
    @(negedge clk_i); frame_i = 1; resync_i = 1; rx_fa_i = 0; msync_i = 1;
    s1_word_i = 4'h5; s2_word_i = 4'hA;
    m_cnt = 1; m_s1 = 4'h5; m_s2 = 4'hA; m_gen = 1; m_last = 0; m_acc[0] = 0;
    @(negedge clk_i); frame_i = 0; resync_i = 0;
    check("R2", "frame_idx priority", frame_idx_o, 1);
    check_all();
    // R9: sync drop and regain
    for (int f = 0; f < 25; f++) step(1'($urandom), (f % 7) != 3, 0, 4'($urandom), 4'($urandom), 1);

    // random mix
    for (int k = 0; k < 600; k++) begin
      bit rs = ($urandom % 53) == 0;
      bit ms = ($urandom % 4) != 0;
      step(1'($urandom), ms, rs, 4'($urandom), 4'($urandom), int'($urandom % 3));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule